// File: doc/BRIEF.md
# Indirect Register File Access Controller

This block carries out a move-indirect operation on one of seven system register files: processor identity, instruction breakpoint, data breakpoint, protection key, performance-monitor configuration, performance-monitor data, and region. Each request carries the following fields:

- a qualifying predicate;
- a read/write direction;
- a file selector;
- a 64-bit index operand;
- a 64-bit write operand;
- the current 2-bit privilege level, where 0 is the most privileged.

The block takes the register number from the index operand. The bit field it uses depends on the target file. It then checks privilege, write permission and existence for that file and direction. A legal access raises a one-hot per-file strobe. A legal write updates the modelled storage, and a legal read returns the register value.

Requests are accepted on a valid/ready handshake. The result appears one cycle after acceptance and is held until it is taken. The result carries the extracted index, the strobe, the read data, and at most one of three faults: privileged operation, illegal write, or reserved register. The performance-monitor files have an architectural part, which is stored. They also have an implementation-dependent part, which returns a computed value on read, drops writes, and never faults.

Top module: `sysreg_indirect`

## Requirements
- R1: When the accepted request has `req_qp` low, the response has no strobe and no fault, and no register changes value.
- R2: The reported index is `req_index[63:61]`, zero-extended, for the region file (code 6). For every other file it is `req_index[7:0]`. All other index bits have no effect.
- R3: A request with `req_pl` not equal to 0 raises `rsp_priv_fault` for the following files: instruction breakpoint (1), data breakpoint (2), protection key (3), monitor configuration (4) and region (6). Such a request gives no strobe and no write.
- R4: The monitor data file (code 5) can be read at every privilege level. A write to it at `req_pl` other than 0 raises `rsp_priv_fault`.
- R5: The identity file (code 0) is read-only. Reading entry i returns `{16'hC0DE, 40'h0, i}`. Any write request to it raises `rsp_illegal_fault`.
- R6: An index at or above the entry count of the target file raises `rsp_rsvd_fault`. The default entry counts are identity 5, breakpoints 8, protection key 16 and region 8. File code 7 always raises this fault. The monitor files (4 and 5) never raise it.
- R7: In the monitor files, indices from `PM_ARCH` up to `PM_ARCH+PM_IMPL-1` (default 8 to 15) read `{16'h1A4D, 40'h0, index}`, and writes to them are dropped. Higher indices read zero. In both cases there is no fault and the file strobe fires.
- R8: Faults are prioritised in the order privilege, then illegal write, then reserved register. Only one fault output is high per response.
- R9: A legal access sets exactly the strobe bit whose position equals the file code. A legal write is returned by a later legal read of the same entry. Reads of registers that have never been written return zero. Writes and faulted operations return zero read data.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. The response is valid on the cycle after acceptance and stays stable while `rsp_ready` is low.
- R11: After reset, `rsp_valid` is low and every stored register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_qp | input | 1 | Qualifying predicate |
| req_write | input | 1 | 1 = write, 0 = read |
| req_file | input | 3 | File code 0..6, with 7 unused |
| req_index | input | 64 | Index operand |
| req_wdata | input | 64 | Write operand |
| req_pl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_index | output | 8 | Extracted index |
| rsp_strobe | output | 7 | One-hot file strobe |
| rsp_rdata | output | 64 | Read data |
| rsp_priv_fault | output | 1 | Privileged-operation fault |
| rsp_illegal_fault | output | 1 | Write to a read-only file |
| rsp_rsvd_fault | output | 1 | Reserved (non-existent) register fault |

## Verification
The vector table walks each file through write-then-read pairs. These pairs show whether storage is per file and per entry, and whether writes land. Index operands carry junk in the ignored bits, and region accesses put their index in the top bits, so a wrong field select shows up as a wrong index or a wrong read value. The same file and index are tried at privilege 0 and at a lower level, and in both directions. This separates the monitor-data read exemption from the privileged files. Boundary indices at, just below and far above each entry count tell the reserved fault apart from the monitor-file exemption. Combined violations expose the fault priority, and a cleared predicate shows that nothing changes. Directed tests cover reset clearing the storage and response holding under back-pressure.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int NUM_FILES = 7;

    typedef enum logic [2:0] {
        FS_IDENT  = 3'd0,
        FS_IBKPT  = 3'd1,
        FS_DBKPT  = 3'd2,
        FS_PKEY   = 3'd3,
        FS_PMCFG  = 3'd4,
        FS_PMDAT  = 3'd5,
        FS_REGION = 3'd6,
        FS_NONE   = 3'd7
    } file_e;

    typedef struct packed {
        logic        qp;
        logic        write;
        file_e       file;
        logic [63:0] index;
        logic [63:0] wdata;
        logic [1:0]  pl;
    } req_t;

    typedef struct packed {
        logic [7:0] idx;
        logic       priv;
        logic       illegal;
        logic       rsvd;
        logic       ok;
        logic       arch;
        logic       impl;
    } dec_t;

    typedef struct packed {
        logic [7:0]           idx;
        logic [NUM_FILES-1:0] strobe;
        logic [63:0]          rdata;
        logic                 priv;
        logic                 illegal;
        logic                 rsvd;
    } rsp_t;

    function automatic logic [63:0] ident_value(input logic [7:0] i);
        return {16'hC0DE, 40'h0, i};
    endfunction

    function automatic logic [63:0] pm_impl_value(input logic [7:0] i);
        return {16'h1A4D, 40'h0, i};
    endfunction

    function automatic logic is_pm(input file_e f);
        return (f == FS_PMCFG) || (f == FS_PMDAT);
    endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_pkg::*;
#(
    parameter int N_IDENT  = 5,
    parameter int N_BKPT   = 8,
    parameter int N_PKEY   = 16,
    parameter int N_REGION = 8,
    parameter int PM_ARCH  = 8,
    parameter int PM_IMPL  = 8
) (
    input  req_t req,
    output dec_t dec
);
    localparam int PM_TOP = PM_ARCH + PM_IMPL;

    logic [7:0] idx;
    logic       priv_file;
    logic       exists;
    logic       pm;

    always_comb begin
        idx = (req.file == FS_REGION) ? {5'b0, req.index[63:61]} : req.index[7:0];
        pm  = is_pm(req.file);

        unique case (req.file)
            FS_IBKPT, FS_DBKPT, FS_PKEY, FS_PMCFG, FS_REGION: priv_file = 1'b1;
            FS_PMDAT: priv_file = req.write;
            default:  priv_file = 1'b0;
        endcase

        unique case (req.file)
            FS_IDENT:           exists = 32'(idx) < N_IDENT;
            FS_IBKPT, FS_DBKPT: exists = 32'(idx) < N_BKPT;
            FS_PKEY:            exists = 32'(idx) < N_PKEY;
            FS_REGION:          exists = 32'(idx) < N_REGION;
            FS_PMCFG, FS_PMDAT: exists = 32'(idx) < PM_ARCH;
            default:            exists = 1'b0;
        endcase

        dec.idx     = idx;
        dec.priv    = req.qp && (req.pl != 2'd0) && priv_file;
        dec.illegal = req.qp && !dec.priv && (req.file == FS_IDENT) && req.write;
        dec.rsvd    = req.qp && !dec.priv && !dec.illegal && !pm && !exists;
        dec.ok      = req.qp && !dec.priv && !dec.illegal && !dec.rsvd;
        dec.arch    = exists;
        dec.impl    = pm && !exists && (32'(idx) < PM_TOP);
    end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
    parameter int DEPTH = 8,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [7:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] a;

    assign a     = addr[AW-1:0];
    assign rdata = (32'(addr) < DEPTH) ? mem[a] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && (32'(addr) < DEPTH)) begin
            mem[a] <= wdata;
        end
    end
endmodule

// File: rtl/sysreg_indirect.sv
module sysreg_indirect
    import sysreg_pkg::*;
#(
    parameter int N_IDENT  = 5,
    parameter int N_BKPT   = 8,
    parameter int N_PKEY   = 16,
    parameter int N_REGION = 8,
    parameter int PM_ARCH  = 8,
    parameter int PM_IMPL  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_qp,
    input  logic        req_write,
    input  logic [2:0]  req_file,
    input  logic [63:0] req_index,
    input  logic [63:0] req_wdata,
    input  logic [1:0]  req_pl,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [7:0]  rsp_index,
    output logic [6:0]  rsp_strobe,
    output logic [63:0] rsp_rdata,
    output logic        rsp_priv_fault,
    output logic        rsp_illegal_fault,
    output logic        rsp_rsvd_fault
);
    function automatic int bank_depth(input int f);
        case (f)
            1, 2:    return N_BKPT;
            3:       return N_PKEY;
            4, 5:    return PM_ARCH;
            6:       return N_REGION;
            default: return 1;
        endcase
    endfunction

    req_t  req;
    dec_t  dec;
    rsp_t  rsp_q, rsp_d;
    logic  accept;
    logic [63:0] bank_rd [NUM_FILES];
    logic [63:0] rd_sel;

    assign req = '{qp: req_qp, write: req_write, file: file_e'(req_file),
                   index: req_index, wdata: req_wdata, pl: req_pl};

    assign req_ready = !rsp_valid || rsp_ready;
    assign accept    = req_valid && req_ready;

    sysreg_decode #(
        .N_IDENT(N_IDENT), .N_BKPT(N_BKPT), .N_PKEY(N_PKEY),
        .N_REGION(N_REGION), .PM_ARCH(PM_ARCH), .PM_IMPL(PM_IMPL)
    ) u_dec (
        .req(req),
        .dec(dec)
    );

    assign bank_rd[FS_IDENT] = (32'(dec.idx) < N_IDENT) ? ident_value(dec.idx) : '0;

    for (genvar f = 1; f < NUM_FILES; f++) begin : g_bank
        logic we;
        assign we = accept && dec.ok && dec.arch && req.write && (req_file == 3'(f));
        sysreg_bank #(.DEPTH(bank_depth(f)), .W(64)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .we   (we),
            .addr (dec.idx),
            .wdata(req_wdata),
            .rdata(bank_rd[f])
        );
    end

    always_comb begin
        if (req.file == FS_NONE)          rd_sel = '0;
        else if (is_pm(req.file) && dec.impl) rd_sel = pm_impl_value(dec.idx);
        else if (is_pm(req.file) && !dec.arch) rd_sel = '0;
        else                              rd_sel = bank_rd[req_file];

        rsp_d.idx     = dec.idx;
        rsp_d.strobe  = '0;
        if (dec.ok && req.file != FS_NONE) rsp_d.strobe[req_file] = 1'b1;
        rsp_d.rdata   = (dec.ok && !req.write) ? rd_sel : '0;
        rsp_d.priv    = dec.priv;
        rsp_d.illegal = dec.illegal;
        rsp_d.rsvd    = dec.rsvd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_q     <= rsp_d;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    assign rsp_index         = rsp_q.idx;
    assign rsp_strobe        = rsp_q.strobe;
    assign rsp_rdata         = rsp_q.rdata;
    assign rsp_priv_fault    = rsp_q.priv;
    assign rsp_illegal_fault = rsp_q.illegal;
    assign rsp_rsvd_fault    = rsp_q.rsvd;

    // R1: a cleared predicate leaves a quiet response
    p_noqp_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_qp) |=> (rsp_valid && rsp_strobe == '0 &&
            !rsp_priv_fault && !rsp_illegal_fault && !rsp_rsvd_fault));

    // R3: privileged files below level 0 always fault
    p_priv_low_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && req_qp && req_pl != 2'd0 &&
         (req_file inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd6})) |=> rsp_priv_fault);

    // R4: monitor data reads never raise a privilege fault
    p_pmd_read_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && req_qp && !req_write && req_file == 3'd5) |=> !rsp_priv_fault);

    // R8: at most one fault per response
    p_one_fault_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_priv_fault, rsp_illegal_fault, rsp_rsvd_fault}) <= 1));

    // R9: strobe is one-hot or empty, and absent when faulted
    p_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($onehot0(rsp_strobe) &&
            !((rsp_strobe != '0) && (rsp_priv_fault || rsp_illegal_fault || rsp_rsvd_fault))));

    // R10: response follows acceptance and holds under back-pressure
    p_accept_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) &&
            $stable(rsp_strobe) && $stable(rsp_index)));
endmodule

// File: tb/tb_sysreg_indirect.sv
module tb_sysreg_indirect;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_qp, req_write;
    logic [2:0]  req_file;
    logic [63:0] req_index, req_wdata;
    logic [1:0]  req_pl;
    logic        rsp_valid, rsp_ready;
    logic [7:0]  rsp_index;
    logic [6:0]  rsp_strobe;
    logic [63:0] rsp_rdata;
    logic        rsp_priv_fault, rsp_illegal_fault, rsp_rsvd_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sysreg_indirect dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_qp(req_qp),
        .req_write(req_write), .req_file(req_file), .req_index(req_index),
        .req_wdata(req_wdata), .req_pl(req_pl),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_index(rsp_index),
        .rsp_strobe(rsp_strobe), .rsp_rdata(rsp_rdata),
        .rsp_priv_fault(rsp_priv_fault), .rsp_illegal_fault(rsp_illegal_fault),
        .rsp_rsvd_fault(rsp_rsvd_fault)
    );

    // fault code: 0 none, 1 privilege, 2 illegal write, 3 reserved
    typedef struct packed {
        logic [3:0]  req;
        logic        qp;
        logic        wr;
        logic [2:0]  file;
        logic [63:0] index;
        logic [63:0] wdata;
        logic [1:0]  pl;
        logic [6:0]  strobe;
        logic [63:0] rdata;
        logic [1:0]  flt;
        logic [7:0]  idx;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        // R9 write breakpoint entry 2
        '{4'd9, 1'b1, 1'b1, 3'd1, 64'h2,                   64'h1111, 2'd0, 7'h02, 64'h0,    2'd0, 8'h02},
        // R2 high junk bits ignored
        '{4'd2, 1'b1, 1'b0, 3'd1, 64'hABCD_0000_0000_0102, 64'h0,    2'd0, 7'h02, 64'h1111, 2'd0, 8'h02},
        // R3 read at level 3
        '{4'd3, 1'b1, 1'b0, 3'd1, 64'h2,                   64'h0,    2'd3, 7'h00, 64'h0,    2'd1, 8'h02},
        // R2 region index from top bits (5)
        '{4'd2, 1'b1, 1'b1, 3'd6, 64'hA000_0000_0000_0000, 64'h5555, 2'd0, 7'h40, 64'h0,    2'd0, 8'h05},
        '{4'd2, 1'b1, 1'b0, 3'd6, 64'hA000_0000_0000_00FF, 64'h0,    2'd0, 7'h40, 64'h5555, 2'd0, 8'h05},
        // R4 monitor data write at level 2 faults
        '{4'd4, 1'b1, 1'b1, 3'd5, 64'h3,                   64'h77,   2'd2, 7'h00, 64'h0,    2'd1, 8'h03},
        // R4 monitor data read at level 2 allowed, unchanged
        '{4'd4, 1'b1, 1'b0, 3'd5, 64'h3,                   64'h0,    2'd2, 7'h20, 64'h0,    2'd0, 8'h03},
        '{4'd4, 1'b1, 1'b1, 3'd5, 64'h3,                   64'h77,   2'd0, 7'h20, 64'h0,    2'd0, 8'h03},
        '{4'd4, 1'b1, 1'b0, 3'd5, 64'h3,                   64'h0,    2'd3, 7'h20, 64'h77,   2'd0, 8'h03},
        // R5 identity read
        '{4'd5, 1'b1, 1'b0, 3'd0, 64'h4,                   64'h0,    2'd3, 7'h01, 64'hC0DE_0000_0000_0004, 2'd0, 8'h04},
        // R5 identity write illegal
        '{4'd5, 1'b1, 1'b1, 3'd0, 64'h1,                   64'h9,    2'd0, 7'h00, 64'h0,    2'd2, 8'h01},
        // R6 identity index 5 reserved
        '{4'd6, 1'b1, 1'b0, 3'd0, 64'h5,                   64'h0,    2'd0, 7'h00, 64'h0,    2'd3, 8'h05},
        // R8 illegal write beats reserved
        '{4'd8, 1'b1, 1'b1, 3'd0, 64'h9,                   64'h0,    2'd0, 7'h00, 64'h0,    2'd2, 8'h09},
        // R6 protection key 16 reserved
        '{4'd6, 1'b1, 1'b0, 3'd3, 64'h10,                  64'h0,    2'd0, 7'h00, 64'h0,    2'd3, 8'h10},
        // R8 privilege beats reserved
        '{4'd8, 1'b1, 1'b0, 3'd3, 64'h10,                  64'h0,    2'd1, 7'h00, 64'h0,    2'd1, 8'h10},
        // R7 monitor config implementation part read
        '{4'd7, 1'b1, 1'b0, 3'd4, 64'hA,                   64'h0,    2'd0, 7'h10, 64'h1A4D_0000_0000_000A, 2'd0, 8'h0A},
        '{4'd7, 1'b1, 1'b1, 3'd4, 64'hA,                   64'h1234, 2'd0, 7'h10, 64'h0,    2'd0, 8'h0A},
        // R7 beyond implementation part: zero, no fault
        '{4'd7, 1'b1, 1'b0, 3'd4, 64'hC8,                  64'h0,    2'd0, 7'h10, 64'h0,    2'd0, 8'hC8},
        // R1 predicate low write
        '{4'd1, 1'b0, 1'b1, 3'd3, 64'h5,                   64'h99,   2'd0, 7'h00, 64'h0,    2'd0, 8'h05},
        '{4'd1, 1'b1, 1'b0, 3'd3, 64'h5,                   64'h0,    2'd0, 7'h08, 64'h0,    2'd0, 8'h05},
        // R6 file code 7
        '{4'd6, 1'b1, 1'b0, 3'd7, 64'h0,                   64'h0,    2'd0, 7'h00, 64'h0,    2'd3, 8'h00},
        // R9 data breakpoint last entry
        '{4'd9, 1'b1, 1'b1, 3'd2, 64'h7,                   64'hD7,   2'd0, 7'h04, 64'h0,    2'd0, 8'h07},
        '{4'd9, 1'b1, 1'b0, 3'd2, 64'h7,                   64'h0,    2'd0, 7'h04, 64'hD7,   2'd0, 8'h07},
        '{4'd6, 1'b1, 1'b0, 3'd2, 64'h8,                   64'h0,    2'd0, 7'h00, 64'h0,    2'd3, 8'h08},
        // R7 dropped write leaves implementation value
        '{4'd7, 1'b1, 1'b0, 3'd4, 64'hA,                   64'h0,    2'd0, 7'h10, 64'h1A4D_0000_0000_000A, 2'd0, 8'h0A}
    };

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] flt_bits(input logic [1:0] f);
        case (f)
            2'd1:    return 3'b100;
            2'd2:    return 3'b010;
            2'd3:    return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    task automatic issue(input logic qp, input logic wr, input logic [2:0] file,
                         input logic [63:0] idx, input logic [63:0] wd, input logic [1:0] pl);
        @(negedge clk);
        req_valid = 1'b1; req_qp = qp; req_write = wr; req_file = file;
        req_index = idx;  req_wdata = wd; req_pl = pl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; rsp_ready = 1'b1;
        req_qp = 1'b0; req_write = 1'b0; req_file = 3'd0;
        req_index = '0; req_wdata = '0; req_pl = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state; R10 ready while idle
        @(negedge clk);
        check("R11 reset rsp_valid", 128'(rsp_valid), 128'(1'b0));
        check("R10 idle req_ready", 128'(req_ready), 128'(1'b1));

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            issue(v.qp, v.wr, v.file, v.index, v.wdata, v.pl);
            check($sformatf("R%0d vec%0d valid", v.req, i), 128'(rsp_valid), 128'(1'b1));
            check($sformatf("R%0d vec%0d result", v.req, i),
                  {45'h0, rsp_index, rsp_strobe, rsp_rdata,
                   rsp_priv_fault, rsp_illegal_fault, rsp_rsvd_fault},
                  {45'h0, v.idx, v.strobe, v.rdata, flt_bits(v.flt)});
        end

        // R10 back-pressure: response holds, ready drops
        @(negedge clk);
        rsp_ready = 1'b0;
        issue(1'b1, 1'b0, 3'd6, 64'hA000_0000_0000_0000, 64'h0, 2'd0);
        check("R10 held valid", 128'(rsp_valid), 128'(1'b1));
        check("R10 ready low", 128'(req_ready), 128'(1'b0));
        @(negedge clk);
        check("R10 held data", {64'h0, rsp_rdata}, {64'h0, 64'h5555});
        check("R10 still valid", 128'(rsp_valid), 128'(1'b1));
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R10 drained", 128'(rsp_valid), 128'(1'b0));

        // R11 reset clears stored registers
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 valid after reset", 128'(rsp_valid), 128'(1'b0));
        issue(1'b1, 1'b0, 3'd1, 64'h2, 64'h0, 2'd0);
        check("R11 breakpoint cleared", {64'h0, rsp_rdata}, 128'h0);
        issue(1'b1, 1'b0, 3'd6, 64'hA000_0000_0000_0000, 64'h0, 2'd0);
        check("R11 region cleared", {64'h0, rsp_rdata}, 128'h0);

        finish_run();
    end
endmodule